// File: doc/BRIEF.md
# Time Slot Switch Processor Port

This block is the host-side register and memory window of a time slot switch. A host drives a 6-bit address, a byte of write data and separate read and write strobes. The top address bit chooses between a single control register and a memory window of 32 byte locations. In the memory window, the low five address bits pick a channel. The memory and the stream page behind that window come from fields held in the control register. The host therefore first programs the control register to aim the window, then reads or writes channels through it.

The memories are not part of this block. It drives a shared synchronous memory address and write-data bus, plus one read enable per memory and one write enable per connection memory. It takes back one read-data bus per memory. A split mode lets the host read received channel bytes from the data memory while its writes still land in a connection memory. The control register also supplies a global processor-enable level to the switching core.

Top module: `tsi_cpu_port`

## Requirements
- R1: With cpuAddr[5] low, a write loads the control register and a read returns it, with bit 5 always read as 0. No memory strobe is raised for such an access.
- R2: With cpuAddr[5] high, memAddr equals {control[2:0], cpuAddr[4:0]}: the stream page above the channel number.
- R3: The memory-select field is control bits 4:3. Outside split mode, a read targets the data memory for code 00, the low connection memory for code 10 and the high connection memory for code 11. A write targets the low connection memory for code 10 and the high connection memory for code 11. At most one memory read enable is active in any cycle.
- R4: Memory-select code 01 is reserved. Window reads then return 0, and window writes raise no memory strobe.
- R5: The data memory is never written. A window write with select code 00 raises no write enable.
- R6: Control bit 7 selects split mode. In split mode every window read comes from the data memory whatever the select code. Window writes go to the connection memory named by select code 10 or 11 and are dropped for codes 00 and 01.
- R7: procEnable equals control bit 6 at all times.
- R8: Read data appears on cpuRdData in the cycle after the read strobe is sampled. In any cycle following one with no read, cpuRdData is 0.
- R9: A write takes effect at the clock edge that samples it, so a read in the next cycle returns the new value.
- R10: Reset clears the control register: split mode off, processor enable off, page 0, select code 00. cpuRdData is 0 after reset.
- R11: When read and write strobes are sampled together, only the write is performed. No read enable is raised, and cpuRdData is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 6 | Host address; bit 5 selects the memory window |
| cpuWrData | input | 8 | Host write data |
| cpuRd | input | 1 | Read strobe, sampled per clock |
| cpuWr | input | 1 | Write strobe, sampled per clock |
| cpuRdData | output | 8 | Read data, one cycle after the read strobe |
| procEnable | output | 1 | Global processor-enable flag for the switching core |
| memAddr | output | 8 | Shared memory address {stream, channel} |
| memWrData | output | 8 | Shared memory write data |
| dmRdEn | output | 1 | Data memory read enable |
| dmRdData | input | 8 | Data memory read data, one cycle after enable |
| cmlRdEn | output | 1 | Low connection memory read enable |
| cmlWrEn | output | 1 | Low connection memory write enable |
| cmlRdData | input | 8 | Low connection memory read data |
| cmhRdEn | output | 1 | High connection memory read enable |
| cmhWrEn | output | 1 | High connection memory write enable |
| cmhRdData | input | 8 | High connection memory read data |

## Verification
The bench builds the block with its defaults: 5 channel bits, 3 stream bits and a byte data path. All eight stream pages of all three memories are therefore reachable, and every one of the 256 locations per memory can be hit by the random phase. These values cover the full control-register decode: all four select codes, split mode on and off, and every page. The bench models the memories at their ports, so window writes, dropped writes and the one-cycle read latency are all observed as the core would see them.

// File: rtl/tsi_cpu_pkg.sv
package tsi_cpu_pkg;

  // memory-select codes held in control bits 4:3
  typedef enum logic [1:0] {
    SEL_DATA    = 2'b00,
    SEL_RSVD    = 2'b01,
    SEL_CONN_LO = 2'b10,
    SEL_CONN_HI = 2'b11
  } memSel_e;

  // source of the byte presented on the read bus next cycle
  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_CTRL    = 3'd1,
    SRC_DATA    = 3'd2,
    SRC_CONN_LO = 3'd3,
    SRC_CONN_HI = 3'd4
  } rdSrc_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic   ctrlWr;
    logic   dmRd;
    logic   cmlRd;
    logic   cmlWr;
    logic   cmhRd;
    logic   cmhWr;
    rdSrc_e rdSrc;
  } accStrobes_t;

  // control register bit positions
  localparam int unsigned SPLIT_BIT = 7;
  localparam int unsigned PE_BIT    = 6;
  localparam int unsigned RSVD_BIT  = 5;
  localparam int unsigned SEL_LO    = 3;

endpackage

// File: rtl/tsi_cpu_decode.sv
module tsi_cpu_decode
  import tsi_cpu_pkg::*;
(
  input  logic        winSel,
  input  logic        cpuRd,
  input  logic        cpuWr,
  input  logic        splitMode,
  input  memSel_e     memSel,
  output accStrobes_t stb
);

  logic doRd;
  logic doWr;

  // a write outranks a read sampled in the same cycle
  assign doWr = cpuWr;
  assign doRd = cpuRd & ~cpuWr;

  always_comb begin
    stb       = '0;
    stb.rdSrc = SRC_NONE;
    if (!winSel) begin
      stb.ctrlWr = doWr;
      if (doRd) stb.rdSrc = SRC_CTRL;
    end else begin
      if (doRd) begin
        if (splitMode) begin
          stb.dmRd  = 1'b1;
          stb.rdSrc = SRC_DATA;
        end else begin
          unique case (memSel)
            SEL_DATA:    begin stb.dmRd  = 1'b1; stb.rdSrc = SRC_DATA;    end
            SEL_CONN_LO: begin stb.cmlRd = 1'b1; stb.rdSrc = SRC_CONN_LO; end
            SEL_CONN_HI: begin stb.cmhRd = 1'b1; stb.rdSrc = SRC_CONN_HI; end
            default:     stb.rdSrc = SRC_NONE;
          endcase
        end
      end
      // data memory has no write path; reserved code drops the write
      unique case (memSel)
        SEL_CONN_LO: stb.cmlWr = doWr;
        SEL_CONN_HI: stb.cmhWr = doWr;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/tsi_cpu_datapath.sv
module tsi_cpu_datapath
  import tsi_cpu_pkg::*;
#(
  parameter int unsigned CHAN_BITS   = 5,
  parameter int unsigned STREAM_BITS = 3,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned MEM_AW     = CHAN_BITS + STREAM_BITS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHAN_BITS-1:0] chanSel,
  input  logic [DATA_W-1:0]    cpuWrData,
  input  accStrobes_t          stb,
  input  logic [DATA_W-1:0]    dmRdData,
  input  logic [DATA_W-1:0]    cmlRdData,
  input  logic [DATA_W-1:0]    cmhRdData,
  output logic [DATA_W-1:0]    ctrlReg,
  output logic [MEM_AW-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic [DATA_W-1:0]    cpuRdData
);

  // bits that hold state; reserved bit is forced low
  localparam logic [DATA_W-1:0] CTRL_MASK = ~(DATA_W'(1) << RSVD_BIT);

  rdSrc_e            rdSrcQ;
  logic [DATA_W-1:0] ctrlSnapQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      rdSrcQ    <= SRC_NONE;
      ctrlSnapQ <= '0;
    end else begin
      if (stb.ctrlWr) ctrlReg <= cpuWrData & CTRL_MASK;
      rdSrcQ <= stb.rdSrc;
      if (stb.rdSrc == SRC_CTRL) ctrlSnapQ <= ctrlReg;
    end
  end

  assign memAddr   = {ctrlReg[STREAM_BITS-1:0], chanSel};
  assign memWrData = cpuWrData;

  always_comb begin
    unique case (rdSrcQ)
      SRC_CTRL:    cpuRdData = ctrlSnapQ;
      SRC_DATA:    cpuRdData = dmRdData;
      SRC_CONN_LO: cpuRdData = cmlRdData;
      SRC_CONN_HI: cpuRdData = cmhRdData;
      default:     cpuRdData = '0;
    endcase
  end

endmodule

// File: rtl/tsi_cpu_port.sv
module tsi_cpu_port
  import tsi_cpu_pkg::*;
#(
  parameter int unsigned CHAN_BITS   = 5,
  parameter int unsigned STREAM_BITS = 3,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned MEM_AW     = CHAN_BITS + STREAM_BITS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CHAN_BITS:0]   cpuAddr,
  input  logic [DATA_W-1:0]    cpuWrData,
  input  logic                 cpuRd,
  input  logic                 cpuWr,
  output logic [DATA_W-1:0]    cpuRdData,
  output logic                 procEnable,
  output logic [MEM_AW-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic                 dmRdEn,
  input  logic [DATA_W-1:0]    dmRdData,
  output logic                 cmlRdEn,
  output logic                 cmlWrEn,
  input  logic [DATA_W-1:0]    cmlRdData,
  output logic                 cmhRdEn,
  output logic                 cmhWrEn,
  input  logic [DATA_W-1:0]    cmhRdData
);

  accStrobes_t       stb;
  logic [DATA_W-1:0] ctrlReg;

  tsi_cpu_decode i_decode (
    .winSel    (cpuAddr[CHAN_BITS]),
    .cpuRd     (cpuRd),
    .cpuWr     (cpuWr),
    .splitMode (ctrlReg[SPLIT_BIT]),
    .memSel    (memSel_e'(ctrlReg[SEL_LO+1:SEL_LO])),
    .stb       (stb)
  );

  tsi_cpu_datapath #(
    .CHAN_BITS   (CHAN_BITS),
    .STREAM_BITS (STREAM_BITS),
    .DATA_W      (DATA_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .chanSel   (cpuAddr[CHAN_BITS-1:0]),
    .cpuWrData (cpuWrData),
    .stb       (stb),
    .dmRdData  (dmRdData),
    .cmlRdData (cmlRdData),
    .cmhRdData (cmhRdData),
    .ctrlReg   (ctrlReg),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .cpuRdData (cpuRdData)
  );

  assign procEnable = ctrlReg[PE_BIT];
  assign dmRdEn     = stb.dmRd;
  assign cmlRdEn    = stb.cmlRd;
  assign cmlWrEn    = stb.cmlWr;
  assign cmhRdEn    = stb.cmhRd;
  assign cmhWrEn    = stb.cmhWr;

endmodule

// File: rtl/tsi_cpu_port_chk.sv
module tsi_cpu_port_chk #(
  parameter int unsigned CHAN_BITS   = 5,
  parameter int unsigned STREAM_BITS = 3,
  parameter int unsigned DATA_W      = 8
)(
  input logic                          clk,
  input logic                          rstN,
  input logic [CHAN_BITS:0]            cpuAddr,
  input logic                          cpuRd,
  input logic                          cpuWr,
  input logic [DATA_W-1:0]             cpuRdData,
  input logic                          procEnable,
  input logic [CHAN_BITS+STREAM_BITS-1:0] memAddr,
  input logic                          dmRdEn,
  input logic                          cmlRdEn,
  input logic                          cmlWrEn,
  input logic                          cmhRdEn,
  input logic                          cmhWrEn
);

  p_ctrl_no_mem_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cpuAddr[CHAN_BITS] |-> !(dmRdEn || cmlRdEn || cmhRdEn || cmlWrEn || cmhWrEn));

  p_chan_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dmRdEn || cmlRdEn || cmhRdEn || cmlWrEn || cmhWrEn)
      |-> (cpuAddr[CHAN_BITS] && memAddr[CHAN_BITS-1:0] == cpuAddr[CHAN_BITS-1:0]));

  p_one_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmRdEn, cmlRdEn, cmhRdEn}));

  p_one_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones({cmlWrEn, cmhWrEn}) <= 1 && (!cpuWr -> !(cmlWrEn || cmhWrEn)));

  p_pe_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuWr && !cpuAddr[CHAN_BITS]) |=> $stable(procEnable));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuRd || cpuWr) |=> cpuRdData == '0);

  p_wr_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr |-> !(dmRdEn || cmlRdEn || cmhRdEn));

endmodule

bind tsi_cpu_port tsi_cpu_port_chk #(
  .CHAN_BITS   (CHAN_BITS),
  .STREAM_BITS (STREAM_BITS),
  .DATA_W      (DATA_W)
) i_chk (.*);

// File: tb/test_tsi_cpu_port.sv
module test_tsi_cpu_port;

  logic       clk = 1'b0;
  logic       rstN;
  logic [5:0] cpuAddr;
  logic [7:0] cpuWrData;
  logic       cpuRd, cpuWr;
  logic [7:0] cpuRdData;
  logic       procEnable;
  logic [7:0] memAddr, memWrData;
  logic       dmRdEn, cmlRdEn, cmlWrEn, cmhRdEn, cmhWrEn;
  logic [7:0] dmRdData, cmlRdData, cmhRdData;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;  // 50 MHz

  tsi_cpu_port i_tsi_cpu_port (.*);

  // ---------- memory models at the ports ----------
  logic [7:0] cmlMem [256];
  logic [7:0] cmhMem [256];

  function automatic logic [7:0] dmPat(input logic [7:0] a);
    return (a * 8'd37) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (dmRdEn)  dmRdData  <= dmPat(memAddr);
    if (cmlRdEn) cmlRdData <= cmlMem[memAddr];
    if (cmhRdEn) cmhRdData <= cmhMem[memAddr];
    if (cmlWrEn) cmlMem[memAddr] <= memWrData;
    if (cmhWrEn) cmhMem[memAddr] <= memWrData;
  end

  // ---------- expected state ----------
  logic [7:0] expCtrl;
  logic [7:0] expCml [256];
  logic [7:0] expCmh [256];

  function automatic logic [7:0] idxOf(input logic [5:0] a);
    return {expCtrl[2:0], a[4:0]};
  endfunction

  function automatic logic [7:0] expRead(input logic [5:0] a);
    if (!a[5]) return expCtrl;
    if (expCtrl[7]) return dmPat(idxOf(a));
    case (expCtrl[4:3])
      2'b00:   return dmPat(idxOf(a));
      2'b10:   return expCml[idxOf(a)];
      2'b11:   return expCmh[idxOf(a)];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // each task starts and ends just after a falling edge
  task automatic doWrite(input logic [5:0] a, input logic [7:0] d, input string req);
    logic expLo, expHi;
    expLo = a[5] && expCtrl[4:3] == 2'b10;
    expHi = a[5] && expCtrl[4:3] == 2'b11;
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1;
    #2;
    chk({req, " wr strobes"}, {dmRdEn, cmlWrEn, cmhWrEn}, {1'b0, expLo, expHi});
    if (a[5]) chk({req, " memAddr"}, memAddr, idxOf(a));
    if (!a[5])     expCtrl = d & 8'hDF;
    else if (expLo) expCml[idxOf(a)] = d;
    else if (expHi) expCmh[idxOf(a)] = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic doRead(input logic [5:0] a, input string req);
    logic [7:0] e;
    e = expRead(a);
    cpuAddr = a; cpuRd = 1'b1;
    @(negedge clk);
    cpuRd = 1'b0;
    chk(req, cpuRdData, e);
  endtask

  task automatic finish();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      cmlMem[i] = 8'h00; cmhMem[i] = 8'h00;
      expCml[i] = 8'h00; expCmh[i] = 8'h00;
    end
    expCtrl = 8'h00;
    dmRdData = '0; cmlRdData = '0; cmhRdData = '0;
    rstN = 1'b0; cpuAddr = '0; cpuWrData = '0; cpuRd = 1'b0; cpuWr = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 rdData", cpuRdData, 8'h00);
    chk("R10 procEnable", procEnable, 1'b0);
    doRead(6'h00, "R10 ctrl");

    // R1 / R7 / R9 control register
    doWrite(6'h00, 8'hFF, "R1");
    chk("R7 pe set", procEnable, 1'b1);
    doRead(6'h07, "R1 R9 readback bit5 zero");
    doWrite(6'h00, 8'h00, "R1");
    chk("R7 pe clear", procEnable, 1'b0);

    // R2 / R3 low connection memory, page 5
    doWrite(6'h00, 8'b0_0_0_10_101, "R1");
    doWrite(6'h23, 8'hA5, "R2 R3 cml");
    doRead(6'h23, "R3 cml read");
    // R3 high connection memory, same location
    doWrite(6'h00, 8'b0_0_0_11_101, "R1");
    doWrite(6'h23, 8'h3C, "R3 cmh");
    doRead(6'h23, "R3 cmh read");
    // R3 / R5 data memory
    doWrite(6'h00, 8'b0_0_0_00_010, "R1");
    doRead(6'h31, "R3 dm read");
    doWrite(6'h31, 8'hEE, "R5 dm write dropped");
    doRead(6'h31, "R5 dm unchanged");
    // R4 reserved select
    doWrite(6'h00, 8'b0_0_0_01_010, "R1");
    doWrite(6'h31, 8'h77, "R4 write dropped");
    doRead(6'h31, "R4 read zero");
    // R6 split mode
    doWrite(6'h00, 8'b1_0_0_10_101, "R1");
    doWrite(6'h24, 8'h9B, "R6 split write cml");
    doRead(6'h24, "R6 split read dm");
    doWrite(6'h00, 8'b1_0_0_00_101, "R1");
    doWrite(6'h24, 8'h11, "R6 split sel00 write dropped");
    doWrite(6'h00, 8'b0_0_0_10_101, "R1");
    doRead(6'h24, "R6 cml holds split write");
    // R8 idle after a read returns zero
    @(negedge clk);
    chk("R8 idle zero", cpuRdData, 8'h00);
    // R11 read and write together
    cpuAddr = 6'h00; cpuWrData = 8'h40; cpuWr = 1'b1; cpuRd = 1'b1;
    #2;
    chk("R11 no rd enable", {dmRdEn, cmlRdEn, cmhRdEn}, 3'b000);
    expCtrl = 8'h40;
    @(negedge clk);
    cpuWr = 1'b0; cpuRd = 1'b0;
    chk("R11 rdData zero", cpuRdData, 8'h00);
    chk("R11 R7 write done", procEnable, 1'b1);

    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned op;
      op = $urandom_range(0, 9);
      if (op < 2) begin
        doWrite(6'($urandom_range(0, 31)), 8'($urandom), "R1 R7 rand ctrl");
        chk("R7 rand pe", procEnable, expCtrl[6]);
      end else if (op < 5) begin
        doWrite(6'h20 | 6'($urandom_range(0, 31)), 8'($urandom), "R3 R6 rand wr");
      end else begin
        doRead(6'($urandom_range(0, 63)), "R3 R4 R6 rand rd");
      end
    end
    finish();
  end

endmodule